// File: doc/BRIEF.md
# Debug Breakpoint Comparator

This unit watches a processor core's memory activity and asks the core to stop when it reaches a chosen address. It holds three address watch registers. The first watches instruction fetch addresses, the second watches load addresses and the third watches store addresses. A debug monitor loads each watch register through a small write port. A written value with bit 0 clear arms that watch at the written address. A written value with bit 0 set disarms it, so no separate enable register is needed.

When an armed watch sees its strobe together with a matching address, the unit raises a halt request in that same cycle. It also reports a two-bit cause code that tells the monitor which watch fired. The request stays latched until the monitor acknowledges it. While the request is latched, the reported cause does not change. The address width is a parameter, and all three watch registers share it.

Top module: `brk_watch`

## Requirements
- R1: After synchronous reset, all three watches are disarmed, `halt_req` is 0 and `halt_cause` is 00.
- R2: A write with `cfg_we`=1 goes to the watch chosen by `cfg_sel` (0 = fetch, 1 = load, 2 = store). If `cfg_addr[0]`=0, that watch is armed at `cfg_addr`.
- R3: A write with `cfg_addr[0]`=1 disarms the chosen watch. A disarmed watch never fires.
- R4: The comparison uses address bits [AW-1:1] only. Bit 0 of the probed address is ignored.
- R5: The fetch watch fires only when `fetch_vld` is high and compares `fetch_pc`. The load watch fires only when `load_vld` is high and the store watch only when `store_vld` is high. Both of these compare `mem_addr`.
- R6: `halt_req` rises in the same cycle as the strobe that matches. No register sits between the match and the output.
- R7: Once a watch fires, `halt_req` stays high until `halt_ack` is seen. While it is held, `halt_cause` keeps the cause of the first fire, even if later fires occur.
- R8: The cause codes are 01 = fetch, 10 = load and 11 = store. When several watches fire in one cycle, fetch wins over load and load wins over store.
- R9: `halt_ack` clears the held request at the next clock edge. If a watch fires in the same cycle as the acknowledge, that new fire is latched instead.
- R10: A write takes effect at the next clock edge. A strobe in the same cycle as the write is compared against the old value.
- R11: A write with `cfg_sel`=3 changes no watch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Watch register write enable |
| cfg_sel | input | 2 | Watch select: 0 fetch, 1 load, 2 store, 3 none |
| cfg_addr | input | AW | Written value; bit 0 set means disarm |
| fetch_vld | input | 1 | Instruction fetch strobe |
| fetch_pc | input | AW | Fetch address |
| load_vld | input | 1 | Load strobe |
| store_vld | input | 1 | Store strobe |
| mem_addr | input | AW | Data access address |
| halt_ack | input | 1 | Monitor acknowledges the halt |
| halt_req | output | 1 | Halt request to the core |
| halt_cause | output | 2 | Cause code of the fire being reported |

## Verification
The hardest situations to reach are coincident events. One is several watches matching in the same cycle, which exercises the priority rule. Another is a new fire arriving while an earlier fire is still held, or arriving in the very cycle of its acknowledge. A further case is a write that lands in the same cycle as a strobe on that same watch. The bench uses a narrow address width so it can arm all three watches together at every even address. It then sweeps every probe address against every non-empty strobe combination. Directed sequences then stack fires, acknowledges and writes into single cycles. A bench-side model predicts the outcome of each of these coincidences.

// File: rtl/brk_pkg.sv
package brk_pkg;

    typedef enum logic [1:0] {
        CAUSE_NONE  = 2'b00,
        CAUSE_FETCH = 2'b01,
        CAUSE_LOAD  = 2'b10,
        CAUSE_STORE = 2'b11
    } cause_e;

    localparam int NUM_SLOTS   = 3;
    localparam int SLOT_FETCH  = 0;
    localparam int SLOT_LOAD   = 1;
    localparam int SLOT_STORE  = 2;

    // The cause code reported for each slot; a lower slot index has priority.
    function automatic cause_e slot_cause(input int idx);
        case (idx)
            SLOT_FETCH: return CAUSE_FETCH;
            SLOT_LOAD:  return CAUSE_LOAD;
            default:    return CAUSE_STORE;
        endcase
    endfunction

endpackage

// File: rtl/brk_slot.sv
module brk_slot #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic          probe_vld,
    input  logic [AW-1:0] probe_addr,
    output logic          hit
);
    localparam logic [AW-1:0] LSB_MASK = {{(AW-1){1'b0}}, 1'b1};

    logic [AW-1:0] bp_q;

    always_ff @(posedge clk) begin
        if (rst)        bp_q <= LSB_MASK;
        else if (wr_en) bp_q <= wr_addr;
    end

    assign hit = probe_vld && !bp_q[0]
              && (((probe_addr ^ bp_q) & ~LSB_MASK) == '0);

    // R2: an even write arms the watch at exactly that address from the next cycle
    a_r2_arm_match: assert property (@(posedge clk) disable iff (rst)
        wr_en && !wr_addr[0] |=>
            (hit == (probe_vld && probe_addr[AW-1:1] == $past(wr_addr[AW-1:1]))));

    // R3: an odd write leaves the watch silent next cycle
    a_r3_disarm: assert property (@(posedge clk) disable iff (rst)
        wr_en && wr_addr[0] |=> !hit);

endmodule

// File: rtl/brk_prio.sv
module brk_prio
    import brk_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_SLOTS-1:0] hits,
    output logic                 any_hit,
    output cause_e               cause
);
    always_comb begin
        cause = CAUSE_NONE;
        for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
            if (hits[i]) cause = slot_cause(i);
        end
    end

    assign any_hit = |hits;

    // R8: a fetch hit is always reported as the fetch cause
    a_r8_fetch_first: assert property (@(posedge clk) disable iff (rst)
        hits[SLOT_FETCH] |-> cause == CAUSE_FETCH);

    // R8: any hit produces a non-empty cause
    a_r8_cause_set: assert property (@(posedge clk) disable iff (rst)
        any_hit |-> cause != CAUSE_NONE);

endmodule

// File: rtl/brk_hold.sv
module brk_hold
    import brk_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   fire,
    input  cause_e fire_cause,
    input  logic   ack,
    output logic   req,
    output cause_e cause_out
);
    logic   held_q;
    cause_e cause_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q  <= 1'b0;
            cause_q <= CAUSE_NONE;
        end else if (ack) begin
            held_q  <= fire;
            cause_q <= fire_cause;
        end else if (!held_q && fire) begin
            held_q  <= 1'b1;
            cause_q <= fire_cause;
        end
    end

    assign req       = held_q | fire;
    assign cause_out = held_q ? cause_q : fire_cause;

    // R7: without an acknowledge a raised request persists with its cause
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        req && !ack |=> req && cause_out == $past(cause_out));

    // R9: after an acknowledge with no new fire, only a fresh fire raises the request
    a_r9_ack_clear: assert property (@(posedge clk) disable iff (rst)
        ack && !fire |=> (req == fire));

endmodule

// File: rtl/brk_watch.sv
module brk_watch
    import brk_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_sel,
    input  logic [AW-1:0] cfg_addr,
    input  logic          fetch_vld,
    input  logic [AW-1:0] fetch_pc,
    input  logic          load_vld,
    input  logic          store_vld,
    input  logic [AW-1:0] mem_addr,
    input  logic          halt_ack,
    output logic          halt_req,
    output logic [1:0]    halt_cause
);
    logic [NUM_SLOTS-1:0] probe_vld;
    logic [NUM_SLOTS-1:0] hits;
    logic                 any_hit;
    cause_e               hit_cause;
    cause_e               out_cause;

    assign probe_vld[SLOT_FETCH] = fetch_vld;
    assign probe_vld[SLOT_LOAD]  = load_vld;
    assign probe_vld[SLOT_STORE] = store_vld;

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        brk_slot #(.AW(AW)) u_slot (
            .clk        (clk),
            .rst        (rst),
            .wr_en      (cfg_we && (cfg_sel == 2'(g))),
            .wr_addr    (cfg_addr),
            .probe_vld  (probe_vld[g]),
            .probe_addr ((g == SLOT_FETCH) ? fetch_pc : mem_addr),
            .hit        (hits[g])
        );
    end

    brk_prio u_prio (
        .clk     (clk),
        .rst     (rst),
        .hits    (hits),
        .any_hit (any_hit),
        .cause   (hit_cause)
    );

    brk_hold u_hold (
        .clk        (clk),
        .rst        (rst),
        .fire       (any_hit),
        .fire_cause (hit_cause),
        .ack        (halt_ack),
        .req        (halt_req),
        .cause_out  (out_cause)
    );

    assign halt_cause = out_cause;

    // R6: a hit is visible on the request in the same cycle
    a_r6_same_cycle: assert property (@(posedge clk) disable iff (rst)
        any_hit |-> halt_req);

    // R5: no strobe, no hit
    a_r5_strobe_gate: assert property (@(posedge clk) disable iff (rst)
        !fetch_vld && !load_vld && !store_vld |-> hits == '0);

endmodule

// File: tb/test_brk_watch.sv
module test_brk_watch;
    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst;
    logic          cfg_we;
    logic [1:0]    cfg_sel;
    logic [AW-1:0] cfg_addr;
    logic          fetch_vld;
    logic [AW-1:0] fetch_pc;
    logic          load_vld;
    logic          store_vld;
    logic [AW-1:0] mem_addr;
    logic          halt_ack;
    logic          halt_req;
    logic [1:0]    halt_cause;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // bench model
    logic [AW-1:0] m_bp [3];
    logic          m_held;
    logic [1:0]    m_cause;

    always #2 clk = ~clk;

    brk_watch #(.AW(AW)) i_brk_watch (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_addr(cfg_addr), .fetch_vld(fetch_vld), .fetch_pc(fetch_pc),
        .load_vld(load_vld), .store_vld(store_vld), .mem_addr(mem_addr),
        .halt_ack(halt_ack), .halt_req(halt_req), .halt_cause(halt_cause)
    );

    function automatic logic m_hit(input logic [AW-1:0] bp, input logic v,
                                   input logic [AW-1:0] a);
        return v && !bp[0] && (a[AW-1:1] == bp[AW-1:1]);
    endfunction

    // One cycle: drive at negedge, check 1 ns later, advance model at posedge.
    task automatic step(input string tag, input logic fv, input logic [AW-1:0] pc,
                        input logic lv, input logic sv, input logic [AW-1:0] ma,
                        input logic ack, input logic we, input logic [1:0] sel,
                        input logic [AW-1:0] wa);
        logic [2:0] h;
        logic [1:0] c_now;
        logic       e_req;
        logic [1:0] e_cause;
        @(negedge clk);
        fetch_vld = fv; fetch_pc = pc; load_vld = lv; store_vld = sv;
        mem_addr = ma; halt_ack = ack; cfg_we = we; cfg_sel = sel; cfg_addr = wa;
        h[0] = m_hit(m_bp[0], fv, pc);
        h[1] = m_hit(m_bp[1], lv, ma);
        h[2] = m_hit(m_bp[2], sv, ma);
        c_now   = h[0] ? 2'b01 : h[1] ? 2'b10 : h[2] ? 2'b11 : 2'b00;
        e_req   = m_held | (h != 3'b000);
        e_cause = m_held ? m_cause : c_now;
        #1;
        n_checks++;
        if (halt_req !== e_req || halt_cause !== e_cause) begin
            n_fail++;
            $display("FAIL %s: req=%0b cause=%0d expected req=%0b cause=%0d",
                     tag, halt_req, halt_cause, e_req, e_cause);
        end
        @(posedge clk);
        if (ack) begin
            m_held  = (h != 3'b000);
            m_cause = c_now;
        end else if (!m_held && h != 3'b000) begin
            m_held  = 1'b1;
            m_cause = c_now;
        end
        if (we && sel != 2'd3) m_bp[sel] = wa;
    endtask

    task automatic idle(input string tag, input logic ack);
        step(tag, 0, '0, 0, 0, '0, ack, 0, 2'd0, '0);
    endtask

    task automatic wr(input string tag, input logic [1:0] sel, input logic [AW-1:0] a);
        step(tag, 0, '0, 0, 0, '0, 0, 1, sel, a);
    endtask

    initial begin
        rst = 1'b1; cfg_we = 0; cfg_sel = 0; cfg_addr = '0; fetch_vld = 0;
        fetch_pc = '0; load_vld = 0; store_vld = 0; mem_addr = '0; halt_ack = 0;
        m_held = 0; m_cause = 0;
        for (int i = 0; i < 3; i++) m_bp[i] = AW'(1);
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1: reset state, and no watch fires on any address
        idle("R1 reset", 0);
        for (int p = 0; p < (1 << AW); p++)
            step("R1 disarmed after reset", 1, AW'(p), 1, 0, AW'(p), 1, 0, 2'd0, '0);

        // R2 R4 R5 R6 R8: all watches armed together, full address x strobe sweep
        for (int a = 0; a < (1 << AW); a += 2) begin
            for (int s = 0; s < 3; s++) wr("R2 arm", 2'(s), AW'(a));
            for (int p = 0; p < (1 << AW); p++) begin
                for (int k = 1; k < 8; k++) begin
                    step("R2/R4/R5/R6/R8 sweep", k[0], AW'(p), k[1], k[2],
                         AW'(p), 0, 0, 2'd0, '0);
                    idle("R7/R9 ack", 1);
                end
            end
        end

        // R5: distinct addresses per watch, cross strobes
        wr("R2", 2'd0, 6'd8); wr("R2", 2'd1, 6'd20); wr("R2", 2'd2, 6'd40);
        step("R5 store strobe on load addr", 0, '0, 0, 1, 6'd20, 0, 0, 2'd0, '0);
        step("R5 load strobe on store addr", 0, '0, 1, 0, 6'd41, 0, 0, 2'd0, '0);
        step("R5 fetch addr on data bus", 0, 6'd20, 1, 1, 6'd8, 0, 0, 2'd0, '0);
        step("R5 load hit", 0, '0, 1, 0, 6'd21, 0, 0, 2'd0, '0);
        idle("R7/R9 ack", 1);

        // R7: held request keeps first cause through later, higher-priority fires
        step("R7 store fires", 0, '0, 0, 1, 6'd40, 0, 0, 2'd0, '0);
        step("R7 fetch while held", 1, 6'd8, 0, 0, '0, 0, 0, 2'd0, '0);
        idle("R7 still held", 0);
        idle("R7 still held", 0);
        // R9: ack with concurrent fire latches the new fire
        step("R9 ack with load fire", 0, '0, 1, 0, 6'd20, 1, 0, 2'd0, '0);
        idle("R9 relatched load", 0);
        idle("R9 clear", 1);
        idle("R9 cleared", 0);

        // R10: write and strobe same cycle compare old value
        step("R10 write new, probe old", 1, 6'd8, 0, 0, '0, 0, 1, 2'd0, 6'd12);
        idle("R10 ack", 1);
        step("R10 old addr gone", 1, 6'd8, 0, 0, '0, 0, 0, 2'd0, '0);
        step("R10 new addr live", 1, 6'd13, 0, 0, '0, 0, 0, 2'd0, '0);
        idle("R10 ack", 1);

        // R11: select 3 touches nothing
        step("R11 sel3 write", 0, '0, 0, 0, '0, 0, 1, 2'd3, 6'd1);
        step("R11 fetch watch intact", 1, 6'd12, 0, 0, '0, 0, 0, 2'd0, '0);
        idle("R11 ack", 1);
        step("R11 load watch intact", 0, '0, 1, 0, 6'd20, 0, 0, 2'd0, '0);
        idle("R11 ack", 1);
        step("R11 store watch intact", 0, '0, 0, 1, 6'd40, 0, 0, 2'd0, '0);
        idle("R11 ack", 1);

        // R3: odd writes disarm; sweep every address and strobe
        for (int s = 0; s < 3; s++) wr("R3 disarm", 2'(s), 6'd13);
        for (int p = 0; p < (1 << AW); p++)
            step("R3 disarmed", 1, AW'(p), 1, 1, AW'(p), 0, 0, 2'd0, '0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        for (int c = 0; c < 150000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run=hung expected=complete");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule